// File: doc/BRIEF.md
# Register Micro-Operation Unit

This block holds a working register and, on each enabled clock edge, replaces it with the result of one selected elementary operation. The second operand arrives on a data port and is used as the source register of the step. The operations cover a plain copy from the source, add, subtract, step up and step down, bitwise logic, and six kinds of one-place shift. Every enabled step also rewrites a five-bit condition word. A shift additionally records the bit that left the register.

A sequencer drives an operation code and a load strobe each cycle. While the strobe stays high, the chosen operation is applied again on every edge. This lets one code count, or walk a value through several shift positions, without further control traffic. Subtraction and decrement reuse the single adder: the second operand is complemented and a carry-in is added.

Top module: `umop_unit`

## Requirements
- R1: After reset the working register, the condition word and the shifted-out bit are all zero.
- R2: When `loadEn` is high at a rising edge with a defined code, the working register takes the result at that edge. The operation repeats on every edge while `loadEn` stays high.
- R3: With `loadEn` low, or with an undefined code (18 to 31), the working register, the condition word and the shifted-out bit keep their values.
- R4: Code 0 copies the operand into the register. Code 1 adds the operand modulo 2^W, with carry set to the carry out and overflow set to the two's-complement overflow.
- R5: Code 2 forms register + ~operand + 1. Carry is set when a borrow occurs, meaning the register is below the operand unsigned. Overflow is set on signed overflow.
- R6: Code 3 adds one and code 4 subtracts one. Carry marks the wrap from all-ones to zero, or the borrow from zero. Overflow marks crossing the signed limit.
- R7: Codes 5, 6 and 7 are AND, OR and XOR with the operand, and code 8 complements the register. Code 9 clears the register by XOR with itself. All five leave carry and overflow at 0.
- R8: Codes 10 and 11 shift left and right with a 0 entering. Codes 16 and 17 shift left and right with `serIn` entering. For every shift, carry and `shiftOut` take the bit that left. `shiftOut` changes only on shifts.
- R9: Codes 12 and 13 rotate left and right, and the bit that leaves re-enters at the other end.
- R10: Code 15 shifts right while keeping the sign bit and copying it downward. Code 14 keeps the sign bit and shifts bits W-2..0 left with 0 entering; bit W-2 leaves. Overflow on code 14 is set when the old bit W-2 differs from the sign.
- R11: The condition word is {sign, zero, carry, overflow, equal}, with sign at bit 4 and equal at bit 0. Sign is the result's top bit and zero marks an all-zero result. Equal marks the pre-step register matching the operand bit for bit. Shifts other than code 14 clear overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opSel | input | 5 | Operation code |
| loadEn | input | 1 | Load strobe; a step happens on each edge while high |
| r2Data | input | W | Source operand |
| serIn | input | 1 | Bit entering on codes 16 and 17 |
| r1Out | output | W | Working register |
| flagsOut | output | 5 | Condition word {sign, zero, carry, overflow, equal} |
| shiftOut | output | 1 | Bit that left the register on the last shift |

## Verification
A wrong adder carry-in or operand inversion shows on `r1Out` and the carry bit one edge after the step that uses it. Because the register feeds back into itself, the error then spreads to every later result. A stale hold path shows as a changed register or condition word on the edge where `loadEn` was low or the code was undefined. A wrong shift fill appears at the end of the register where the bit entered, and a wrong choice of leaving bit appears on `shiftOut` and carry in that same cycle. The equal flag compares the operand against the register value from before the step, so an off-by-one-cycle compare shows up as soon as the operand matches the old value but not the new one.

// File: rtl/umop_pkg.sv
`timescale 1ns/1ps
package umop_pkg;
  typedef enum logic [4:0] {
    OP_MOVE = 5'd0,  OP_ADD  = 5'd1,  OP_SUB  = 5'd2,  OP_INC  = 5'd3,
    OP_DEC  = 5'd4,  OP_AND  = 5'd5,  OP_OR   = 5'd6,  OP_XOR  = 5'd7,
    OP_NOT  = 5'd8,  OP_CLR  = 5'd9,  OP_SHL  = 5'd10, OP_SHR  = 5'd11,
    OP_ROL  = 5'd12, OP_ROR  = 5'd13, OP_ASL  = 5'd14, OP_ASR  = 5'd15,
    OP_SHLI = 5'd16, OP_SHRI = 5'd17
  } uop_e;

  localparam int unsigned OP_LAST = 17;

  typedef struct packed {
    logic sign;
    logic zero;
    logic carry;
    logic ovf;
    logic equal;
  } flags_t;

  typedef struct packed {
    logic wrR1;
    logic wrFlags;
    logic wrShOut;
    uop_e op;
  } strobe_t;
endpackage

// File: rtl/umop_ctrl.sv
`timescale 1ns/1ps
module umop_ctrl
  import umop_pkg::*;
(
  input  logic [4:0] opSel,
  input  logic       loadEn,
  output strobe_t    strb
);
  logic legal;
  logic isShift;

  always_comb begin
    legal   = (32'(opSel) <= OP_LAST);
    isShift = 1'b0;
    case (opSel)
      OP_SHL, OP_SHR, OP_ROL, OP_ROR,
      OP_ASL, OP_ASR, OP_SHLI, OP_SHRI: isShift = 1'b1;
      default:                          isShift = 1'b0;
    endcase
    strb.op      = legal ? uop_e'(opSel) : OP_MOVE;
    strb.wrR1    = loadEn && legal;
    strb.wrFlags = loadEn && legal;
    strb.wrShOut = loadEn && legal && isShift;
  end
endmodule

// File: rtl/umop_alu.sv
`timescale 1ns/1ps
module umop_alu
  import umop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  uop_e           op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           serIn,
  output logic [W-1:0]   res,
  output flags_t         flg,
  output logic           outBit
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] addB;
  logic         addCin;
  logic         borrowMode;
  logic [W-1:0] lowAdd;
  logic [1:0]   topAdd;
  logic [W-1:0] sum;
  logic         cMsb;
  logic         cOut;
  logic         addOvf;
  logic         cy;
  logic         ov;

  // adder operand selection: subtract and decrement reuse the adder
  always_comb begin
    addB       = b;
    addCin     = 1'b0;
    borrowMode = 1'b0;
    case (op)
      OP_SUB: begin addB = ~b;          addCin = 1'b1; borrowMode = 1'b1; end
      OP_INC: begin addB = '0;          addCin = 1'b1; end
      OP_DEC: begin addB = '1;          addCin = 1'b0; borrowMode = 1'b1; end
      default: begin addB = b;          addCin = 1'b0; end
    endcase
  end

  assign lowAdd = {1'b0, a[MSB-1:0]} + {1'b0, addB[MSB-1:0]} + {{MSB{1'b0}}, addCin};
  assign cMsb   = lowAdd[MSB];
  assign topAdd = {1'b0, a[MSB]} + {1'b0, addB[MSB]} + {1'b0, cMsb};
  assign cOut   = topAdd[1];
  assign sum    = {topAdd[0], lowAdd[MSB-1:0]};
  assign addOvf = cMsb ^ cOut;

  always_comb begin
    res    = a;
    cy     = 1'b0;
    ov     = 1'b0;
    outBit = 1'b0;
    case (op)
      OP_MOVE: res = b;
      OP_ADD, OP_SUB, OP_INC, OP_DEC: begin
        res = sum;
        cy  = borrowMode ? ~cOut : cOut;
        ov  = addOvf;
      end
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_NOT:  res = ~a;
      OP_CLR:  res = a ^ a;
      OP_SHL:  begin res = {a[MSB-1:0], 1'b0};    outBit = a[MSB]; cy = a[MSB]; end
      OP_SHR:  begin res = {1'b0, a[MSB:1]};      outBit = a[0];   cy = a[0];   end
      OP_SHLI: begin res = {a[MSB-1:0], serIn};   outBit = a[MSB]; cy = a[MSB]; end
      OP_SHRI: begin res = {serIn, a[MSB:1]};     outBit = a[0];   cy = a[0];   end
      OP_ROL:  begin res = {a[MSB-1:0], a[MSB]};  outBit = a[MSB]; cy = a[MSB]; end
      OP_ROR:  begin res = {a[0], a[MSB:1]};      outBit = a[0];   cy = a[0];   end
      OP_ASR:  begin res = {a[MSB], a[MSB:1]};    outBit = a[0];   cy = a[0];   end
      OP_ASL: begin
        res    = {a[MSB], a[MSB-2:0], 1'b0};
        outBit = a[MSB-1];
        cy     = a[MSB-1];
        ov     = a[MSB] ^ a[MSB-1];
      end
      default: res = a;
    endcase
  end

  assign flg.sign  = res[MSB];
  assign flg.zero  = ~|res;
  assign flg.carry = cy;
  assign flg.ovf   = ov;
  assign flg.equal = ~|(a ^ b);
endmodule

// File: rtl/umop_datapath.sv
`timescale 1ns/1ps
module umop_datapath
  import umop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  strobe_t      strb,
  input  logic [W-1:0] r2Data,
  input  logic         serIn,
  output logic [W-1:0] r1Q,
  output flags_t       flagsQ,
  output logic         shOutQ
);
  logic [W-1:0] aluRes;
  flags_t       aluFlg;
  logic         aluOut;

  umop_alu #(.W(W)) u_alu (
    .op     (strb.op),
    .a      (r1Q),
    .b      (r2Data),
    .serIn  (serIn),
    .res    (aluRes),
    .flg    (aluFlg),
    .outBit (aluOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r1Q    <= '0;
      flagsQ <= '0;
      shOutQ <= 1'b0;
    end else begin
      if (strb.wrR1)    r1Q    <= aluRes;
      if (strb.wrFlags) flagsQ <= aluFlg;
      if (strb.wrShOut) shOutQ <= aluOut;
    end
  end

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFlags |=> (flagsQ.zero == (r1Q == '0)) && (flagsQ.sign == r1Q[W-1]));

  // R9
  rotate_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrR1 && (strb.op == OP_ROL || strb.op == OP_ROR))
      |=> $countones(r1Q) == $countones($past(r1Q)));

  // R10
  asr_sign_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrR1 && (strb.op == OP_ASR || strb.op == OP_ASL))
      |=> r1Q[W-1] == $past(r1Q[W-1]));

  // R7
  clear_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrR1 && strb.op == OP_CLR)
      |=> (r1Q == '0) && !flagsQ.carry && !flagsQ.ovf);

  // R8
  shout_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrShOut |=> shOutQ == flagsQ.carry);
endmodule

// File: rtl/umop_unit.sv
`timescale 1ns/1ps
module umop_unit
  import umop_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [4:0]   opSel,
  input  logic         loadEn,
  input  logic [W-1:0] r2Data,
  input  logic         serIn,
  output logic [W-1:0] r1Out,
  output logic [4:0]   flagsOut,
  output logic         shiftOut
);
  strobe_t strb;
  flags_t  flagsQ;

  umop_ctrl u_ctrl (
    .opSel  (opSel),
    .loadEn (loadEn),
    .strb   (strb)
  );

  umop_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .r2Data (r2Data),
    .serIn  (serIn),
    .r1Q    (r1Out),
    .flagsQ (flagsQ),
    .shOutQ (shiftOut)
  );

  assign flagsOut = flagsQ;

  // R3
  hold_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!loadEn || 32'(opSel) > OP_LAST)
      |=> $stable(r1Out) && $stable(flagsOut) && $stable(shiftOut));

  // R7
  logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadEn && opSel >= 5'd5 && opSel <= 5'd9)
      |=> !flagsOut[2] && !flagsOut[1]);
endmodule

// File: tb/umop_unit_tb.sv
`timescale 1ns/1ps
module umop_unit_tb;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [4:0]   opSel = '0;
  logic         loadEn = 1'b0;
  logic [W-1:0] r2Data = '0;
  logic         serIn = 1'b0;
  logic [W-1:0] r1Out;
  logic [4:0]   flagsOut;
  logic         shiftOut;

  int vecCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  umop_unit #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .loadEn(loadEn),
    .r2Data(r2Data), .serIn(serIn), .r1Out(r1Out),
    .flagsOut(flagsOut), .shiftOut(shiftOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expectAll(input string req, input int r1e, input int fe);
    chk(req, "r1", int'(r1Out), r1e);
    chk(req, "flags", int'(flagsOut), fe);
  endtask

  // apply one code for n consecutive edges, sample after
  task automatic stepN(input int op, input int v, input bit s, input int n);
    @(negedge clk);
    opSel = op[4:0]; r2Data = v[W-1:0]; serIn = s; loadEn = 1'b1;
    for (int i = 0; i < n; i++) @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic step(input int op, input int v, input bit s);
    stepN(op, v, s, 1);
  endtask

  task automatic tResetState();
    expectAll("R1", 'h00, 'h00);
    chk("R1", "shiftOut", int'(shiftOut), 0);
  endtask

  task automatic tMoveAdd();
    step(0, 'h5A, 0); expectAll("R4", 'h5A, 'b00000);
    step(1, 'h30, 0); expectAll("R4", 'h8A, 'b10010);
    step(1, 'h80, 0); expectAll("R4", 'h0A, 'b00110);
  endtask

  task automatic tSub();
    step(2, 'h0A, 0); expectAll("R5 R11", 'h00, 'b01001);
    step(2, 'h01, 0); expectAll("R5", 'hFF, 'b10100);
    step(0, 'h80, 0);
    step(2, 'h01, 0); expectAll("R5", 'h7F, 'b00010);
  endtask

  task automatic tIncDec();
    step(3, 'h33, 0); expectAll("R6", 'h80, 'b10010);
    step(0, 'h00, 0);
    step(4, 'h33, 0); expectAll("R6", 'hFF, 'b10100);
    step(0, 'h80, 0);
    step(4, 'h33, 0); expectAll("R6", 'h7F, 'b00010);
  endtask

  task automatic tRepeat();
    step(0, 'hFE, 0);
    stepN(3, 'h33, 0, 2); expectAll("R2", 'h00, 'b01100);
    step(3, 'h33, 0);     expectAll("R2", 'h01, 'b00000);
  endtask

  task automatic tLogic();
    step(0, 'hAA, 0); step(5, 'hCC, 0); expectAll("R7", 'h88, 'b10000);
    step(0, 'hAA, 0); step(6, 'hCC, 0); expectAll("R7", 'hEE, 'b10000);
    step(0, 'hAA, 0); step(7, 'hCC, 0); expectAll("R7", 'h66, 'b00000);
    step(0, 'hAA, 0); step(8, 'h33, 0); expectAll("R7", 'h55, 'b00000);
    step(0, 'hFF, 0); step(1, 'h01, 0); expectAll("R4", 'h00, 'b01100);
    step(6, 'h00, 0); expectAll("R7 R11", 'h00, 'b01001);
    step(0, 'hF0, 0); step(1, 'h20, 0); expectAll("R4", 'h10, 'b00100);
    step(9, 'h33, 0); expectAll("R7", 'h00, 'b01000);
  endtask

  task automatic tShifts();
    step(0, 'h96, 0); step(10, 'h33, 0); expectAll("R8", 'h2C, 'b00100);
    chk("R8", "shiftOut", int'(shiftOut), 1);
    step(0, 'h96, 0);
    chk("R8", "shiftOut held", int'(shiftOut), 1);
    step(11, 'h33, 0); expectAll("R8", 'h4B, 'b00000);
    chk("R8", "shiftOut", int'(shiftOut), 0);
    step(0, 'h96, 0); step(16, 'h33, 1); expectAll("R8", 'h2D, 'b00100);
    step(0, 'h96, 0); step(17, 'h33, 1); expectAll("R8", 'hCB, 'b10000);
    step(0, 'h96, 0); step(12, 'h33, 0); expectAll("R9", 'h2D, 'b00100);
    step(0, 'h97, 0); step(13, 'h33, 0); expectAll("R9", 'hCB, 'b10100);
    chk("R9", "shiftOut", int'(shiftOut), 1);
  endtask

  task automatic tArith();
    step(0, 'h96, 0); step(15, 'h33, 0); expectAll("R10", 'hCB, 'b10000);
    step(0, 'h40, 0); step(15, 'h33, 0); expectAll("R10", 'h20, 'b00000);
    step(0, 'h96, 0); step(14, 'h33, 0); expectAll("R10", 'hAC, 'b10010);
    step(0, 'h23, 0); step(14, 'h33, 0); expectAll("R10", 'h46, 'b00000);
    step(0, 'hE1, 0); step(14, 'h33, 0); expectAll("R10", 'hC2, 'b10100);
    chk("R10", "shiftOut", int'(shiftOut), 1);
  endtask

  task automatic tHold();
    step(0, 'h5C, 0);
    step(12, 'h33, 0);
    @(negedge clk);
    opSel = 5'd1; r2Data = 'h11; loadEn = 1'b0;
    @(negedge clk);
    expectAll("R3", 'hB8, 'b10000);
    chk("R3", "shiftOut", int'(shiftOut), 0);
    step(20, 'h11, 1);
    expectAll("R3", 'hB8, 'b10000);
    step(31, 'h11, 1);
    expectAll("R3", 'hB8, 'b10000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tMoveAdd();
    tSub();
    tIncDec();
    tRepeat();
    tLogic();
    tShifts();
    tArith();
    tHold();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      vecCnt++;
      errCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end
endmodule